// File: doc/BRIEF.md
# Two-Block Ping-Pong Transfer FIFO

This block moves 16-bit words from a host register port to a consumer that a DMA engine drives. The host first writes a control register to pick the transfer direction. When host-write mode is on, it pushes words through a data register and polls a full flag in the status word. The words are held in two 4-word blocks that are used in turn. One block fills from the host while the other waits for the consumer or is drained by it.

When a block holds four words, the block raises a request line to the consumer. The consumer takes the words one per acknowledge, in the order they were written. The request stays up until all four words of that block are gone. Full asserts only when both blocks are complete, so a host with no draining gets exactly eight words in. A write to the control register empties both blocks, cancels any pending request and loads the new mode.

Top module: `pingpong_xfer_fifo`

## Requirements
- R1: After reset, status bit 7 (full) is 0, status bit 6 (empty) is 1, status bit 2 (mode) is 0 and `dreq` is 0.
- R2: A write with `host_sel`=0 loads status bit 2 from `host_wdata` bit 2. The value 1 enables host-write mode. While the mode is 0, writes with `host_sel`=1 are ignored and `dreq` stays 0.
- R3: Starting from empty with no acknowledges, the first 7 data writes leave status bit 7 at 0. The 8th data write sets it to 1 in the following cycle.
- R4: `dreq` goes to 1 in the cycle after the 4th word of a block is written. A block holding fewer than 4 words never raises `dreq`.
- R5: While `dreq` is 1, `cons_rdata` shows the next unread word of the draining block. Each `dack` advances to the next word in the order the words were written. `dreq` stays 1 until the 4th `dack` of that block.
- R6: Blocks fill and drain in strict alternation, starting with block A. The second group of four words written comes out after the first group.
- R7: A data write while status bit 7 is 1 is ignored. No stored word changes and the full flag stays set.
- R8: Any write with `host_sel`=0 empties both blocks. In the next cycle, full is 0, empty is 1 and `dreq` is 0. A `dack` in the same cycle has no effect.
- R9: Status bit 6 is 1 exactly when both blocks hold no words.
- R10: A `dack` while `dreq` is 0 is ignored. No word is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 1 | Register select: 0 control, 1 data |
| host_wdata | input | 16 | Host write data |
| host_status | output | 16 | Status word: bit 7 full, bit 6 empty, bit 2 mode |
| dreq | output | 1 | Consumer request: one complete block is waiting |
| dack | input | 1 | Consumer read strobe, one word per cycle |
| cons_rdata | output | 16 | Word currently offered to the consumer |

## Verification
A host data write and a consumer acknowledge can land in the same cycle. In one case the write fills one block while the acknowledge drains the other. In another, the final acknowledge frees a block in the same cycle that a write meets the full flag, and that write must still be lost. A control write can also coincide with an acknowledge, and the flush must win. Random stimulus drives writes and acknowledges independently each cycle, with occasional control writes. Directed steps provoke each collision on purpose. A bench model of the two blocks, built from the requirements, predicts the request line, the status bits and the offered word after every cycle.

// File: rtl/ppf_pkg.sv
package ppf_pkg;
   typedef enum logic {
      SEL_CTRL = 1'b0,
      SEL_DATA = 1'b1
   } host_sel_e;

   localparam int ST_FULL_BIT  = 7;
   localparam int ST_EMPTY_BIT = 6;
   localparam int ST_MODE_BIT  = 2;
endpackage

// File: rtl/ppf_block.sv
module ppf_block #(
   parameter int DW          = 16,
   parameter int DEPTH       = 4,
   parameter bit RESET_STORE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_adv,
   output logic          complete,
   output logic          vacant,
   output logic          fill_done,
   output logic          drain_done,
   output logic [DW-1:0] rd_data
);
   localparam int CW = $clog2(DEPTH + 1);
   localparam int RW = $clog2(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("ppf_block: DEPTH must be at least 2");
   end
   if ((1 << RW) != DEPTH) begin : g_bad_pow2
      $error("ppf_block: DEPTH must be a power of two");
   end

   logic [CW-1:0] wcnt;
   logic [RW-1:0] rcnt;
   logic [RW-1:0] widx;
   logic [DW-1:0] mem [DEPTH];

   assign widx       = wcnt[RW-1:0];
   assign complete   = (wcnt == CW'(DEPTH));
   assign vacant     = (wcnt == '0);
   assign fill_done  = wr_en && (wcnt == CW'(DEPTH - 1));
   assign drain_done = rd_adv && (rcnt == RW'(DEPTH - 1));
   assign rd_data    = mem[rcnt];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wcnt <= '0;
         rcnt <= '0;
      end else if (flush || drain_done) begin
         wcnt <= '0;
         rcnt <= '0;
      end else begin
         if (wr_en && !complete) wcnt <= wcnt + 1'b1;
         if (rd_adv) rcnt <= rcnt + 1'b1;
      end
   end

   if (RESET_STORE) begin : g_store_rst
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
         end else if (wr_en && !complete) begin
            mem[widx] <= wr_data;
         end
      end
   end else begin : g_store_plain
      always_ff @(posedge clk) begin
         if (wr_en && !complete) mem[widx] <= wr_data;
      end
   end

   // R7
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wcnt <= CW'(DEPTH));

   // R10
   adv_needs_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_adv |-> complete);
endmodule

// File: rtl/ppf_turn.sv
module ppf_turn (
   input  logic clk,
   input  logic rst_n,
   input  logic flush,
   input  logic fill_done,
   input  logic drain_done,
   output logic fsel,
   output logic dsel
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fsel <= 1'b0;
         dsel <= 1'b0;
      end else if (flush) begin
         fsel <= 1'b0;
         dsel <= 1'b0;
      end else begin
         if (fill_done)  fsel <= ~fsel;
         if (drain_done) dsel <= ~dsel;
      end
   end
endmodule

// File: rtl/ppf_ctrl.sv
module ppf_ctrl #(
   parameter int SW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctrl_wr,
   input  logic          mode_bit_in,
   input  logic          full,
   input  logic          empty,
   output logic          mode,
   output logic [SW-1:0] status
);
   import ppf_pkg::*;

   if (SW <= ST_FULL_BIT) begin : g_bad_sw
      $error("ppf_ctrl: status width too small for the flag positions");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode <= 1'b0;
      else if (ctrl_wr) mode <= mode_bit_in;
   end

   always_comb begin
      status               = '0;
      status[ST_FULL_BIT]  = full;
      status[ST_EMPTY_BIT] = empty;
      status[ST_MODE_BIT]  = mode;
   end
endmodule

// File: rtl/pingpong_xfer_fifo.sv
module pingpong_xfer_fifo #(
   parameter int DW          = 16,
   parameter int DEPTH       = 4,
   parameter bit RESET_STORE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_we,
   input  logic          host_sel,
   input  logic [DW-1:0] host_wdata,
   output logic [DW-1:0] host_status,
   output logic          dreq,
   input  logic          dack,
   output logic [DW-1:0] cons_rdata
);
   import ppf_pkg::*;

   localparam int NBLK = 2;

   logic            flush;
   logic            accept;
   logic            full;
   logic            empty;
   logic            mode;
   logic            fsel;
   logic            dsel;
   logic [NBLK-1:0] blk_wr;
   logic [NBLK-1:0] blk_adv;
   logic [NBLK-1:0] blk_complete;
   logic [NBLK-1:0] blk_vacant;
   logic [NBLK-1:0] blk_fill_done;
   logic [NBLK-1:0] blk_drain_done;
   logic [DW-1:0]   blk_rdata [NBLK];

   assign flush  = host_we && (host_sel == SEL_CTRL);
   assign accept = host_we && (host_sel == SEL_DATA) && mode && !full;
   assign full   = &blk_complete;
   assign empty  = &blk_vacant;
   assign dreq   = mode && blk_complete[dsel];

   for (genvar i = 0; i < NBLK; i++) begin : g_blk
      assign blk_wr[i]  = accept && (fsel == i[0]);
      assign blk_adv[i] = dreq && dack && !flush && (dsel == i[0]);
      ppf_block #(
         .DW          (DW),
         .DEPTH       (DEPTH),
         .RESET_STORE (RESET_STORE)
      ) u_blk (
         .clk        (clk),
         .rst_n      (rst_n),
         .flush      (flush),
         .wr_en      (blk_wr[i]),
         .wr_data    (host_wdata),
         .rd_adv     (blk_adv[i]),
         .complete   (blk_complete[i]),
         .vacant     (blk_vacant[i]),
         .fill_done  (blk_fill_done[i]),
         .drain_done (blk_drain_done[i]),
         .rd_data    (blk_rdata[i])
      );
   end

   assign cons_rdata = blk_rdata[dsel];

   ppf_turn u_turn (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .fill_done  (|blk_fill_done),
      .drain_done (|blk_drain_done),
      .fsel       (fsel),
      .dsel       (dsel)
   );

   ppf_ctrl #(.SW(DW)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctrl_wr     (flush),
      .mode_bit_in (host_wdata[ST_MODE_BIT]),
      .full        (full),
      .empty       (empty),
      .mode        (mode),
      .status      (host_status)
   );

   // R3
   full_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_status[ST_FULL_BIT] |-> !host_status[ST_EMPTY_BIT]);

   // R8
   flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!dreq && host_status[ST_EMPTY_BIT] && !host_status[ST_FULL_BIT]));

   // R5
   dreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dreq && !dack && !flush) |=> dreq);

   // R5
   offer_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dreq && !dack && !flush) |=> $stable(cons_rdata));

   // R2
   idle_no_dreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !host_status[ST_MODE_BIT] |-> !dreq);

   // R7
   full_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_status[ST_FULL_BIT] && host_we && host_sel && !dack) |=> host_status[ST_FULL_BIT]);
endmodule

// File: tb/pingpong_xfer_fifo_tb_top.sv
`timescale 1ns/1ps
module pingpong_xfer_fifo_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_we = 1'b0;
   logic        host_sel = 1'b0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_status;
   logic        dreq;
   logic        dack = 1'b0;
   logic [15:0] cons_rdata;

   always #2.5 clk = ~clk;

   pingpong_xfer_fifo dut_i (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
      .host_wdata(host_wdata), .host_status(host_status), .dreq(dreq),
      .dack(dack), .cons_rdata(cons_rdata)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [15:0] m_data [2][4];
   int m_w [2];
   int m_fsel, m_dsel, m_rptr;
   bit m_mode;

   function automatic bit m_full();  return (m_w[0] == 4) && (m_w[1] == 4); endfunction
   function automatic bit m_empty(); return (m_w[0] == 0) && (m_w[1] == 0); endfunction
   function automatic bit m_dreq();  return m_mode && (m_w[m_dsel] == 4); endfunction

   task automatic chk(bit ok, string tag, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic compare(string tag);
      chk(dreq == m_dreq(), tag, "dreq", dreq, m_dreq());
      chk(host_status[7] == m_full(), tag, "full bit", host_status[7], m_full());
      chk(host_status[6] == m_empty(), tag, "empty bit", host_status[6], m_empty());
      chk(host_status[2] == m_mode, tag, "mode bit", host_status[2], m_mode);
      if (m_dreq())
         chk(cons_rdata == m_data[m_dsel][m_rptr], tag, "cons_rdata",
             cons_rdata, m_data[m_dsel][m_rptr]);
   endtask

   task automatic m_apply(bit we, bit sel, logic [15:0] wd, bit ak);
      bit pre_dreq = m_dreq();
      bit pre_full = m_full();
      if (we && !sel) begin
         m_w[0] = 0; m_w[1] = 0; m_fsel = 0; m_dsel = 0; m_rptr = 0;
         m_mode = wd[2];
         return;
      end
      if (we && sel && m_mode && !pre_full) begin
         m_data[m_fsel][m_w[m_fsel]] = wd;
         m_w[m_fsel]++;
         if (m_w[m_fsel] == 4) m_fsel ^= 1;
      end
      if (ak && pre_dreq) begin
         m_rptr++;
         if (m_rptr == 4) begin
            m_rptr = 0;
            m_w[m_dsel] = 0;
            m_dsel ^= 1;
         end
      end
   endtask

   task automatic cyc(bit we, bit sel, logic [15:0] wd, bit ak, string tag);
      host_we = we; host_sel = sel; host_wdata = wd; dack = ak;
      m_apply(we, sel, wd, ak);
      @(negedge clk);
      host_we = 1'b0; dack = 1'b0;
      compare(tag);
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      m_w[0] = 0; m_w[1] = 0; m_fsel = 0; m_dsel = 0; m_rptr = 0; m_mode = 0;
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state, R9 empty bit
      compare("R1");
      chk(host_status == 16'h0040, "R9", "status word", host_status, 16'h0040);

      // R2 mode off: data ignored
      cyc(1, 0, 16'h0000, 0, "R2");
      cyc(1, 1, 16'h1111, 0, "R2");
      chk(host_status[6] == 1'b1, "R2", "empty after ignored write", host_status[6], 1);
      cyc(1, 0, 16'h0004, 0, "R2");

      // R4 partial block, R10 dack without dreq
      cyc(1, 1, 16'hA000, 0, "R4");
      cyc(1, 1, 16'hA001, 1, "R10");
      cyc(1, 1, 16'hA002, 0, "R4");
      chk(dreq == 1'b0, "R4", "dreq on partial block", dreq, 0);
      cyc(1, 1, 16'hA003, 0, "R4");
      chk(dreq == 1'b1, "R4", "dreq after 4th word", dreq, 1);

      // R3 fill to eight
      for (int i = 0; i < 3; i++) cyc(1, 1, 16'hB000 + 16'(i), 0, "R3");
      chk(host_status[7] == 1'b0, "R3", "full after 7", host_status[7], 0);
      cyc(1, 1, 16'hB003, 0, "R3");
      chk(host_status[7] == 1'b1, "R3", "full after 8", host_status[7], 1);

      // R7 write while full
      cyc(1, 1, 16'hDEAD, 0, "R7");

      // R5 drain order, R7 collision: last dack with write at full
      for (int i = 0; i < 3; i++) begin
         chk(cons_rdata == 16'hA000 + 16'(i), "R5", "order A", cons_rdata, 16'hA000 + i);
         cyc(0, 1, 16'h0, 1, "R5");
      end
      cyc(1, 1, 16'hBEEF, 1, "R7");
      chk(host_status[7] == 1'b0, "R7", "full cleared by drain", host_status[7], 0);

      // R6 second block follows
      for (int i = 0; i < 4; i++) begin
         chk(cons_rdata == 16'hB000 + 16'(i), "R6", "order B", cons_rdata, 16'hB000 + i);
         cyc(0, 1, 16'h0, 1, "R6");
      end
      chk(host_status[6] == 1'b1, "R9", "empty after drain", host_status[6], 1);

      // R8 flush colliding with dack
      for (int i = 0; i < 5; i++) cyc(1, 1, 16'hC000 + 16'(i), 0, "R8");
      cyc(1, 0, 16'h0004, 1, "R8");
      chk(dreq == 1'b0, "R8", "dreq after flush", dreq, 0);

      // Random phase
      for (int n = 0; n < 4000; n++) begin
         int r = int'($urandom_range(0, 99));
         bit ak = ($urandom_range(0, 99) < 45);
         logic [15:0] wd = 16'($urandom);
         if (r < 3) begin
            if ($urandom_range(0, 9) < 8) wd[2] = 1'b1;
            cyc(1, 0, wd, ak, "RND");
         end else if (r < 58) begin
            cyc(1, 1, wd, ak, "RND");
         end else begin
            cyc(0, 1, wd, ak, "RND");
         end
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule